// File: doc/BRIEF.md
# Masked Circular-Queue Address Generator

This block forms operand addresses for a multiply-accumulate datapath that walks data arrays with post-increment pointers. It keeps a mask register that is 32 bits wide as seen by software but holds state only in its low 16 bits. The upper half always reads back as ones. Each address request carries its own mask-enable flag. When the flag is set, the pointer value is ANDed with the full 32-bit mask view to give the final address. The pointer advanced by the access size is ANDed the same way. Clearing low mask bits therefore confines the pointer to a power-of-two region, and the pointer wraps there like a circular queue, with no compare or modulo logic.

Requests enter on a valid/ready port and leave through a single registered response stage with its own valid/ready pair. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its result appears on the response port after that edge. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and `req_ready` stays low, so back-pressure reaches the requester in the same cycle. The mask write/read port is a plain control path with no handshake.

Top module: `circq_agen`

## Requirements
- R1: After reset the mask reads back as 32'hFFFF_FFFF and `rsp_valid` is low.
- R2: A mask write keeps only bits [15:0] of `mask_wr_data`. A read returns 16'hFFFF in bits [31:16] and the stored value in bits [15:0]. With no write, the read value does not change.
- R3: For an accepted request with `req_mask_en`=1, `rsp_addr` equals `req_areg` AND {16'hFFFF, mask[15:0]}.
- R4: For an accepted request with `req_mask_en`=0, `rsp_addr` equals `req_areg`, and `rsp_areg_next` equals `req_areg` plus the access size, with no masking.
- R5: With `req_mask_en`=1, `rsp_areg_next` equals (`rsp_addr` + access size) AND {16'hFFFF, mask[15:0]}. A pointer at the last slot of the region wraps to the first slot.
- R6: `req_size` 0 selects a word access (increment 2). `req_size` 1 selects a longword access (increment 4).
- R7: A mask write takes effect for requests accepted from the next clock edge on. A request accepted on the same edge as the write uses the old mask.
- R8: When `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and `rsp_addr`/`rsp_areg_next` hold their values. A response is handed over and a new request taken on the same edge when `rsp_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_data | input | 32 | Mask write value (only [15:0] kept) |
| mask_rd_data | output | 32 | Mask read value, upper half ones |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_areg | input | 32 | Address-register (pointer) value |
| req_size | input | 1 | 0 word, 1 longword |
| req_mask_en | input | 1 | Apply mask to this request |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_addr | output | 32 | Final operand address |
| rsp_areg_next | output | 32 | Post-incremented pointer value |

## Verification
If the stored mask bits were wrong, the next masked request would return an address with bits set outside the region, or lose bits inside it. The mask read port would show the same error one cycle after the write. A wrong increment or unmasked sum shows up as a pointer that leaves the region, visible in `rsp_areg_next` on the response right after acceptance. Broken response hold logic shows as a response that changes under a stall, or as a request swallowed without a response, within one cycle of the stall starting.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic {
    ACC_WORD = 1'b0,
    ACC_LONG = 1'b1
  } acc_size_e;

  function automatic logic [2:0] size_bytes(acc_size_e s);
    return (s == ACC_LONG) ? 3'd4 : 3'd2;
  endfunction
endpackage

// File: rtl/agen_mask_reg.sv
module agen_mask_reg #(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [MASK_W-1:0] mask_bits,
  output logic [ADDR_W-1:0] rd_data
);
  localparam int HI_W = ADDR_W - MASK_W;

  logic [MASK_W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     store_q <= '1;
    else if (wr_en) store_q <= wr_data[MASK_W-1:0];
  end

  assign mask_bits = store_q;
  assign rd_data   = {{HI_W{1'b1}}, store_q};

  AST_WR_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[MASK_W-1:0] == $past(wr_data[MASK_W-1:0])); // R2
  AST_NO_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $past(rst_n)) |=> $stable(rd_data)); // R2
endmodule

// File: rtl/agen_addr_calc.sv
module agen_addr_calc
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 16
) (
  input  logic [ADDR_W-1:0] areg,
  input  acc_size_e         size,
  input  logic              mask_en,
  input  logic [MASK_W-1:0] mask_bits,
  output logic [ADDR_W-1:0] final_addr,
  output logic [ADDR_W-1:0] next_areg
);
  localparam int HI_W = ADDR_W - MASK_W;

  logic [ADDR_W-1:0] full_mask;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    full_mask  = {{HI_W{1'b1}}, mask_bits};
    step       = {{(ADDR_W-3){1'b0}}, size_bytes(size)};
    final_addr = mask_en ? (areg & full_mask) : areg;
    sum        = final_addr + step;
    next_areg  = mask_en ? (sum & full_mask) : sum;
  end
endmodule

// File: rtl/agen_rsp_stage.sv
module agen_rsp_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) dat_q <= in_data;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8
endmodule

// File: rtl/circq_agen.sv
module circq_agen
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr_en,
  input  logic [ADDR_W-1:0] mask_wr_data,
  output logic [ADDR_W-1:0] mask_rd_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_areg,
  input  logic              req_size,
  input  logic              req_mask_en,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ADDR_W-1:0] rsp_areg_next
);
  localparam int PAIR_W = 2 * ADDR_W;

  logic [MASK_W-1:0] mask_bits;
  logic [ADDR_W-1:0] calc_addr;
  logic [ADDR_W-1:0] calc_next;
  logic [PAIR_W-1:0] rsp_pair;
  acc_size_e         size_sel;

  assign size_sel = acc_size_e'(req_size);

  agen_mask_reg #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (mask_wr_en),
    .wr_data   (mask_wr_data),
    .mask_bits (mask_bits),
    .rd_data   (mask_rd_data)
  );

  agen_addr_calc #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_calc (
    .areg       (req_areg),
    .size       (size_sel),
    .mask_en    (req_mask_en),
    .mask_bits  (mask_bits),
    .final_addr (calc_addr),
    .next_areg  (calc_next)
  );

  agen_rsp_stage #(.DATA_W(PAIR_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   ({calc_addr, calc_next}),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (rsp_pair)
  );

  assign rsp_addr      = rsp_pair[PAIR_W-1:ADDR_W];
  assign rsp_areg_next = rsp_pair[ADDR_W-1:0];

  logic take;
  assign take = req_valid && req_ready;

  AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid); // R8
  AST_MASKED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mask_en) |=> rsp_addr == ($past(req_areg) & $past(mask_rd_data))); // R3
  AST_PASS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_mask_en) |=> rsp_addr == $past(req_areg)); // R4
  AST_PTR_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mask_en) |=> (rsp_areg_next & ~$past(mask_rd_data)) == '0); // R5
endmodule

// File: tb/sim_circq_agen.sv
`timescale 1ns/1ps
module sim_circq_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mask_wr_en = 1'b0;
  logic [31:0] mask_wr_data = '0;
  logic [31:0] mask_rd_data;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_areg = '0;
  logic        req_size = 1'b0;
  logic        req_mask_en = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic [31:0] rsp_areg_next;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  circq_agen u0 (
    .clk(clk), .rst_n(rst_n),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data), .mask_rd_data(mask_rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_areg(req_areg),
    .req_size(req_size), .req_mask_en(req_mask_en),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_areg_next(rsp_areg_next)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic write_mask(logic [31:0] v);
    @(negedge clk);
    mask_wr_en = 1'b1; mask_wr_data = v;
    @(negedge clk);
    mask_wr_en = 1'b0;
  endtask

  // one request with rsp_ready high; result sampled one step after the accepting edge
  task automatic issue(logic [31:0] a, logic sz, logic en,
                       output logic [31:0] o_addr, output logic [31:0] o_next);
    @(negedge clk);
    req_valid = 1'b1; req_areg = a; req_size = sz; req_mask_en = en; rsp_ready = 1'b1;
    @(posedge clk); #1;
    chk("R8 rsp_valid after accept", {31'd0, rsp_valid}, 32'd1);
    o_addr = rsp_addr; o_next = rsp_areg_next;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mask after reset", mask_rd_data, 32'hFFFF_FFFF);
    chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_mask_rw();
    write_mask(32'h1234_00F0);
    chk("R2 readback upper ones", mask_rd_data, 32'hFFFF_00F0);
    write_mask(32'h0000_A5C3);
    chk("R2 readback second", mask_rd_data, 32'hFFFF_A5C3);
    repeat (2) @(negedge clk);
    chk("R2 held without write", mask_rd_data, 32'hFFFF_A5C3);
  endtask

  task automatic t_passthrough();
    logic [31:0] a, n;
    write_mask(32'h0000_000F);
    issue(32'hDEAD_BEEF, 1'b1, 1'b0, a, n);
    chk("R4 addr unmasked", a, 32'hDEAD_BEEF);
    chk("R4 next unmasked long", n, 32'hDEAD_BEF3);
    issue(32'h0000_FFFE, 1'b0, 1'b0, a, n);
    chk("R4 addr unmasked word", a, 32'h0000_FFFE);
    chk("R6 word step unmasked", n, 32'h0001_0000);
  endtask

  task automatic t_wrap_long();
    logic [31:0] a, n, p;
    write_mask(32'h0000_003C);
    p = 32'h1234_ABC0;
    for (int i = 0; i < 20; i++) begin
      issue(p, 1'b1, 1'b1, a, n);
      chk("R3 long ring addr", a, 32'h1234_0000 + 32'((i % 16) * 4));
      chk("R5 long ring next", n, 32'h1234_0000 + 32'(((i + 1) % 16) * 4));
      p = n;
    end
  endtask

  task automatic t_wrap_word();
    logic [31:0] a, n;
    write_mask(32'h0000_001E);
    issue(32'h5555_001E, 1'b0, 1'b1, a, n);
    chk("R3 word last slot", a, 32'h5555_001E);
    chk("R5 R6 word wrap", n, 32'h5555_0000);
    issue(32'h5555_0007, 1'b0, 1'b1, a, n);
    chk("R3 word strips low bit", a, 32'h5555_0006);
    chk("R6 word step 2", n, 32'h5555_0008);
  endtask

  task automatic t_same_edge_write();
    logic [31:0] a, n;
    write_mask(32'h0000_00FF);
    @(negedge clk);
    mask_wr_en = 1'b1; mask_wr_data = 32'h0000_000F;
    req_valid = 1'b1; req_areg = 32'h0000_0ABC; req_size = 1'b1; req_mask_en = 1'b1;
    @(posedge clk); #1;
    chk("R7 same-edge uses old mask", rsp_addr, 32'h0000_00BC);
    @(negedge clk);
    mask_wr_en = 1'b0; req_valid = 1'b0;
    issue(32'h0000_0ABC, 1'b1, 1'b1, a, n);
    chk("R7 next request uses new mask", a, 32'h0000_000C);
    chk("R7 R5 next wraps under new mask", n, 32'h0000_0000);
  endtask

  task automatic t_backpressure();
    write_mask(32'h0000_FFFF);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_areg = 32'h0000_1000; req_size = 1'b1; req_mask_en = 1'b0;
    @(posedge clk); #1;
    chk("R8 first taken", rsp_addr, 32'h0000_1000);
    @(negedge clk);
    req_areg = 32'h0000_2000;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R8 held addr", rsp_addr, 32'h0000_1000);
      chk("R8 held next", rsp_areg_next, 32'h0000_1004);
      chk("R8 req_ready low", {31'd0, req_ready}, 32'd0);
    end
    @(negedge clk);
    rsp_ready = 1'b1;
    #1 chk("R8 ready follows consumer", {31'd0, req_ready}, 32'd1);
    @(posedge clk); #1;
    chk("R8 second after release", rsp_addr, 32'h0000_2000);
    chk("R8 valid after release", {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk("R8 drains", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 t_reset();
    t_mask_rw();
    t_passthrough();
    t_wrap_long();
    t_wrap_word();
    t_same_edge_write();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule